// File: doc/BRIEF.md
# Scratchpad Ring DMA Copier

This block copies a run of 16-byte quadwords between a large main memory and a 16 KB on-chip scratchpad, in either direction. Software programs a main-memory address, a scratchpad address and a quadword count through a small register bus. It then sets the start bit, together with a direction bit, in the control register. The engine moves one quadword on every clock in which both the source and the destination port report ready. When the count reaches zero it drops the start bit and raises a one-cycle completion pulse.

The scratchpad address is a ring pointer. It steps by 16 after every quadword and folds back to zero past the top of the scratchpad, so a single transfer can run across the wrap. The main-memory side steps by 16 in a straight line, and the address it drives is the register value modulo the RAM size. When copying into the scratchpad, a source address that lies inside a small vector-unit memory window is routed to a separate vector-memory read port, as an offset from the window base. The final values of the address registers stay readable after the transfer.

Top module: `spad_dma`

## Requirements
- R1: After reset all four registers read zero, `done` is low, and no memory port is enabled.
- R2: A write to the main-address register (select 1) keeps bits 30:4 and clears bit 31 and bits 3:0, so writing 0xFFFFFFFF reads back 0x7FFFFFF0.
- R3: A write to the scratchpad-address register (select 3) keeps bits 13:4 only, so writing 0xFFFFFFFF reads back 0x00003FF0.
- R4: Control register (select 0): bit 0 is start/busy and bit 1 is direction (1 = main memory into scratchpad, 0 = scratchpad into main memory). The count register is select 2. With a nonzero count, a start copies exactly that many quadwords at ascending addresses, one per clock while both ports are ready, so the first quadword moves on the clock edge after the start write.
- R5: The scratchpad address steps by 16 per quadword and wraps from 0x3FF0 to 0x0000 without a break in the transfer. Its final value can be read back.
- R6: The main address register steps by 16 per quadword without wrapping. The main-memory port address is that value modulo 2^MM_AW (32 MB by default).
- R7: When copying into the scratchpad, a source address in [VU_BASE, VU_BASE+2^VU_AW) (default 0x11000000 to 0x11000FFF) is read from the vector port at offset address-VU_BASE, and any other source address is read from main memory. When copying out of the scratchpad, the destination is always main memory.
- R8: The cycle after the last quadword moves, the start bit reads 0, the count reads 0, and `done` is high for exactly one cycle.
- R9: Starting with a count of zero raises `done` one cycle after the start write, and no memory port is enabled.
- R10: In a cycle where the source or the destination port is not ready, no quadword moves and the count and both addresses hold.
- R11: While a transfer is busy, register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 main address, 2 count, 3 scratchpad address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mm_en | output | 1 | Main-memory access request |
| mm_wr | output | 1 | Main-memory access is a write |
| mm_addr | output | MM_AW | Main-memory byte address |
| mm_wdata | output | 128 | Main-memory write data |
| mm_rdata | input | 128 | Main-memory read data, same cycle |
| mm_ready | input | 1 | Main memory accepts or returns data this cycle |
| sp_en | output | 1 | Scratchpad access request |
| sp_wr | output | 1 | Scratchpad access is a write |
| sp_addr | output | SP_AW | Scratchpad byte address |
| sp_wdata | output | 128 | Scratchpad write data |
| sp_rdata | input | 128 | Scratchpad read data, same cycle |
| sp_ready | input | 1 | Scratchpad accepts or returns data this cycle |
| vu_en | output | 1 | Vector-memory read request |
| vu_addr | output | VU_AW | Vector-memory byte offset |
| vu_rdata | input | 128 | Vector-memory read data, same cycle |
| vu_ready | input | 1 | Vector memory returns data this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
A start write takes effect on the edge that samples it. A transfer of N quadwords with both ports ready then moves data on the next N edges, and `done` is visible at the Nth falling edge after the write task returns. For a zero count this is the first falling edge. The bench drives and samples only on falling edges and counts falling edges until `done` appears, so an early or late pulse is reported as an error. Register values and captured memory writes are checked after the pulse, and stall behaviour is checked at fixed falling edges while a ready input is held low.

// File: rtl/spad_dma_pkg.sv
// Package: shared constants and register-select encoding for the
// scratchpad ring DMA copier. Assumes 16-byte quadwords and a 32-bit
// register bus.
package spad_dma_pkg;
    localparam int QW_BYTES = 16;
    localparam int QW_SHIFT = $clog2(QW_BYTES);
    localparam int QW_W     = QW_BYTES * 8;
    localparam int REG_W    = 32;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_MADDR = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_SPAD  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/spad_dma_regs.sv
// Register file and transfer sequencer. Holds control, main address,
// quadword count and scratchpad ring index. Advances them on each beat
// and ends the run with a one-cycle done pulse.
// Assumes: beat is only asserted while active is high.
module spad_dma_regs
    import spad_dma_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int SP_AW = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             beat,
    output logic             busy,
    output logic             active,
    output logic             to_spad,
    output logic [REG_W-1:0] maddr,
    output logic [SP_AW-QW_SHIFT-1:0] sp_idx,
    output logic             done
);
    localparam int SP_IW  = SP_AW - QW_SHIFT;
    localparam int MADR_W = REG_W - 1 - QW_SHIFT;

    logic              run_q;
    logic              dir_q;
    logic [MADR_W-1:0] madr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SP_IW-1:0]  sidx_q;
    logic              done_q;
    logic              unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_W-1], reg_wdata[QW_SHIFT-1:2]};

    // Sequencer plus register writes; writes only land while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            dir_q  <= 1'b0;
            madr_q <= '0;
            cnt_q  <= '0;
            sidx_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (run_q) begin
                if (cnt_q == '0) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end else if (beat) begin
                    cnt_q  <= cnt_q - 1'b1;
                    madr_q <= madr_q + 1'b1;
                    sidx_q <= sidx_q + 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end else if (reg_wr) begin
                case (reg_sel_e'(reg_sel))
                    SEL_CTRL: begin
                        run_q <= reg_wdata[0];
                        dir_q <= reg_wdata[1];
                    end
                    SEL_MADDR: madr_q <= reg_wdata[REG_W-2:QW_SHIFT];
                    SEL_COUNT: cnt_q  <= reg_wdata[CNT_W-1:0];
                    SEL_SPAD:  sidx_q <= reg_wdata[SP_AW-1:QW_SHIFT];
                    default:   ;
                endcase
            end
        end
    end

    // Read-back mux for the register bus.
    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_CTRL:  reg_rdata = {{(REG_W-2){1'b0}}, dir_q, run_q};
            SEL_MADDR: reg_rdata = {1'b0, madr_q, {QW_SHIFT{1'b0}}};
            SEL_COUNT: reg_rdata = {{(REG_W-CNT_W){1'b0}}, cnt_q};
            default:   reg_rdata = {{(REG_W-SP_AW){1'b0}}, sidx_q, {QW_SHIFT{1'b0}}};
        endcase
    end

    assign busy    = run_q;
    assign active  = run_q && (cnt_q != '0);
    assign to_spad = dir_q;
    assign maddr   = {1'b0, madr_q, {QW_SHIFT{1'b0}}};
    assign sp_idx  = sidx_q;
    assign done    = done_q;

    // R4: each beat consumes exactly one quadword of count
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && beat) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: ring index advances by one quadword and wraps at the top
    assert_spad_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && beat) |=> (sidx_q == SP_IW'($past(sidx_q) + 1'b1)));

    // R10: no beat means both addresses and the count hold
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !beat) |=> ($stable(madr_q) && $stable(sidx_q) && $stable(cnt_q)));

    // R8: completion is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/spad_dma_route.sv
// Port router: chooses source and destination memories for the current
// quadword, decodes the vector-memory window on the copy into the
// scratchpad, and forms the beat when source and destination are ready.
// Assumes: all three memories return read data in the cycle they are ready.
module spad_dma_route
    import spad_dma_pkg::*;
#(
    parameter int              MM_AW   = 25,
    parameter int              SP_AW   = 14,
    parameter int              VU_AW   = 12,
    parameter logic [REG_W-1:0] VU_BASE = 32'h1100_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       active,
    input  logic                       to_spad,
    input  logic [REG_W-1:0]           maddr,
    input  logic [SP_AW-QW_SHIFT-1:0]  sp_idx,
    output logic                       beat,
    output logic                       mm_en,
    output logic                       mm_wr,
    output logic [MM_AW-1:0]           mm_addr,
    output logic [QW_W-1:0]            mm_wdata,
    input  logic [QW_W-1:0]            mm_rdata,
    input  logic                       mm_ready,
    output logic                       sp_en,
    output logic                       sp_wr,
    output logic [SP_AW-1:0]           sp_addr,
    output logic [QW_W-1:0]            sp_wdata,
    input  logic [QW_W-1:0]            sp_rdata,
    input  logic                       sp_ready,
    output logic                       vu_en,
    output logic [VU_AW-1:0]           vu_addr,
    input  logic [QW_W-1:0]            vu_rdata,
    input  logic                       vu_ready
);
    localparam logic [REG_W-1:0] VU_BYTES = REG_W'(1) << VU_AW;

    logic [REG_W-1:0] win_off;
    logic             in_win;
    logic             src_rdy;
    logic             dst_rdy;

    // Window decode, applied only when the scratchpad is the destination.
    always_comb begin
        win_off = maddr - VU_BASE;
        in_win  = to_spad && (maddr >= VU_BASE) && (win_off < VU_BYTES);
    end

    // Per-direction enables; write strobes wait for valid source data.
    always_comb begin
        if (to_spad) begin
            src_rdy = in_win ? vu_ready : mm_ready;
            dst_rdy = sp_ready;
            mm_en   = active && !in_win;
            vu_en   = active && in_win;
            sp_en   = active && src_rdy;
        end else begin
            src_rdy = sp_ready;
            dst_rdy = mm_ready;
            sp_en   = active;
            mm_en   = active && sp_ready;
            vu_en   = 1'b0;
        end
        beat = active && src_rdy && dst_rdy;
    end

    assign mm_wr    = !to_spad;
    assign sp_wr    = to_spad;
    assign mm_addr  = maddr[MM_AW-1:0];
    assign vu_addr  = win_off[VU_AW-1:0];
    assign sp_addr  = {sp_idx, {QW_SHIFT{1'b0}}};
    assign mm_wdata = sp_rdata;
    assign sp_wdata = in_win ? vu_rdata : mm_rdata;

    // R9: an idle or empty run touches no memory
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !(mm_en || sp_en || vu_en));

    // R7: a source quadword comes from exactly one memory
    assert_one_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        to_spad |-> !(mm_en && vu_en));

    // R7: the vector port is never used when leaving the scratchpad
    assert_vu_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !to_spad |-> !vu_en);
endmodule

// File: rtl/spad_dma.sv
// Top of the scratchpad ring DMA copier: register file and sequencer
// plus port router. Assumes a single clock and synchronous active-low reset.
module spad_dma
    import spad_dma_pkg::*;
#(
    parameter int              MM_AW   = 25,
    parameter int              SP_AW   = 14,
    parameter int              VU_AW   = 12,
    parameter int              CNT_W   = 16,
    parameter logic [31:0]     VU_BASE = 32'h1100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mm_en,
    output logic              mm_wr,
    output logic [MM_AW-1:0]  mm_addr,
    output logic [127:0]      mm_wdata,
    input  logic [127:0]      mm_rdata,
    input  logic              mm_ready,
    output logic              sp_en,
    output logic              sp_wr,
    output logic [SP_AW-1:0]  sp_addr,
    output logic [127:0]      sp_wdata,
    input  logic [127:0]      sp_rdata,
    input  logic              sp_ready,
    output logic              vu_en,
    output logic [VU_AW-1:0]  vu_addr,
    input  logic [127:0]      vu_rdata,
    input  logic              vu_ready,
    output logic              done
);
    localparam int SP_IW = SP_AW - QW_SHIFT;

    logic             beat;
    logic             busy;
    logic             active;
    logic             to_spad;
    logic [31:0]      maddr;
    logic [SP_IW-1:0] sp_idx;

    spad_dma_regs #(
        .CNT_W (CNT_W),
        .SP_AW (SP_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .beat      (beat),
        .busy      (busy),
        .active    (active),
        .to_spad   (to_spad),
        .maddr     (maddr),
        .sp_idx    (sp_idx),
        .done      (done)
    );

    spad_dma_route #(
        .MM_AW   (MM_AW),
        .SP_AW   (SP_AW),
        .VU_AW   (VU_AW),
        .VU_BASE (VU_BASE)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .to_spad  (to_spad),
        .maddr    (maddr),
        .sp_idx   (sp_idx),
        .beat     (beat),
        .mm_en    (mm_en),
        .mm_wr    (mm_wr),
        .mm_addr  (mm_addr),
        .mm_wdata (mm_wdata),
        .mm_rdata (mm_rdata),
        .mm_ready (mm_ready),
        .sp_en    (sp_en),
        .sp_wr    (sp_wr),
        .sp_addr  (sp_addr),
        .sp_wdata (sp_wdata),
        .sp_rdata (sp_rdata),
        .sp_ready (sp_ready),
        .vu_en    (vu_en),
        .vu_addr  (vu_addr),
        .vu_rdata (vu_rdata),
        .vu_ready (vu_ready)
    );

    // R8: the pulse only follows the end of a run
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/spad_dma_tb.sv
module spad_dma_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_sel = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mm_en, mm_wr, sp_en, sp_wr, vu_en, done;
    logic [24:0]  mm_addr;
    logic [13:0]  sp_addr;
    logic [11:0]  vu_addr;
    logic [127:0] mm_wdata, mm_rdata, sp_wdata, sp_rdata, vu_rdata;
    logic         mm_ready = 1'b1, sp_ready = 1'b1, vu_ready = 1'b1;

    int total = 0;
    int bad = 0;

    logic [127:0] spad_mem [1024];
    logic [24:0]  wlog_addr [64];
    logic [127:0] wlog_data [64];
    int           wlog_n = 0;
    int           en_cycles = 0;
    int           vu_cycles = 0;

    always #5 clk = ~clk;

    function automatic logic [127:0] mm_pat(input logic [24:0] a);
        return {32'hC0DE0000, 7'd0, a, 32'h1111_0001, 7'd0, a};
    endfunction
    function automatic logic [127:0] vu_pat(input logic [11:0] a);
        return {32'hFACE0000, 20'd0, a, 64'h2};
    endfunction
    function automatic logic [127:0] sp_pat(input logic [9:0] i);
        return {32'h5E5E0000, 22'd0, i, 64'h3};
    endfunction

    assign mm_rdata = mm_pat(mm_addr);
    assign vu_rdata = vu_pat(vu_addr);
    assign sp_rdata = sp_pat(sp_addr[13:4]);

    // Memory models: capture completed writes and port activity.
    always @(posedge clk) begin
        if (sp_en && sp_wr && sp_ready) spad_mem[sp_addr[13:4]] <= sp_wdata;
        if (mm_en && mm_wr && mm_ready) begin
            wlog_addr[wlog_n % 64] <= mm_addr;
            wlog_data[wlog_n % 64] <= mm_wdata;
            wlog_n <= wlog_n + 1;
        end
        if (mm_en || sp_en || vu_en) en_cycles <= en_cycles + 1;
        if (vu_en) vu_cycles <= vu_cycles + 1;
    end

    spad_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mm_en(mm_en), .mm_wr(mm_wr), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_rdata(mm_rdata), .mm_ready(mm_ready),
        .sp_en(sp_en), .sp_wr(sp_wr), .sp_addr(sp_addr), .sp_wdata(sp_wdata),
        .sp_rdata(sp_rdata), .sp_ready(sp_ready),
        .vu_en(vu_en), .vu_addr(vu_addr), .vu_rdata(vu_rdata), .vu_ready(vu_ready),
        .done(done)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [31:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    // Counts falling edges until done and checks the pulse timing.
    task automatic wait_done(input string req, input int exp_edges);
        int got = -1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (done) begin got = k; break; end
        end
        chk(req, 128'(got), 128'(exp_edges));
        @(negedge clk);
        chk({req, " single pulse"}, 128'(done), 128'(0));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            chk("R1 reg zero", 128'(v), 128'(0));
        end
        chk("R1 done low", 128'(done), 128'(0));
        chk("R1 ports idle", 128'({mm_en, sp_en, vu_en}), 128'(0));
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr_reg(2'd1, 32'hFFFF_FFFF);
        rd_reg(2'd1, v);
        chk("R2 main addr mask", 128'(v), 128'(32'h7FFF_FFF0));
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_reg(2'd3, v);
        chk("R3 spad addr mask", 128'(v), 128'(32'h0000_3FF0));
    endtask

    task automatic t_to_spad();
        logic [31:0] v;
        wr_reg(2'd1, 32'h0000_0100);
        wr_reg(2'd3, 32'h0000_0040);
        wr_reg(2'd2, 32'd4);
        wr_reg(2'd0, 32'h3);
        wait_done("R8 done after 4 beats", 4);
        for (int i = 0; i < 4; i++)
            chk("R4 spad data", spad_mem[4 + i], mm_pat(25'(32'h100 + 16 * i)));
        rd_reg(2'd1, v); chk("R4 main addr end", 128'(v), 128'(32'h140));
        rd_reg(2'd3, v); chk("R5 spad addr end", 128'(v), 128'(32'h80));
        rd_reg(2'd2, v); chk("R8 count zero", 128'(v), 128'(0));
        rd_reg(2'd0, v); chk("R8 start cleared", 128'(v), 128'(32'h2));
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr_reg(2'd1, 32'h0000_0200);
        wr_reg(2'd3, 32'h0000_3FE0);
        wr_reg(2'd2, 32'd4);
        wr_reg(2'd0, 32'h3);
        wait_done("R5 wrap done timing", 4);
        chk("R5 before top", spad_mem[10'h3FE], mm_pat(25'h200));
        chk("R5 top", spad_mem[10'h3FF], mm_pat(25'h210));
        chk("R5 after wrap", spad_mem[10'h000], mm_pat(25'h220));
        chk("R5 after wrap+1", spad_mem[10'h001], mm_pat(25'h230));
        rd_reg(2'd3, v); chk("R5 spad addr after wrap", 128'(v), 128'(32'h20));
    endtask

    task automatic t_modulo();
        logic [31:0] v;
        int base = wlog_n;
        wr_reg(2'd1, 32'h01FF_FFE0);
        wr_reg(2'd3, 32'h0000_0100);
        wr_reg(2'd2, 32'd3);
        wr_reg(2'd0, 32'h1);
        wait_done("R6 done timing", 3);
        chk("R6 write count", 128'(wlog_n - base), 128'(3));
        chk("R6 addr 0", 128'(wlog_addr[base % 64]), 128'(25'h1FF_FFE0));
        chk("R6 addr 1", 128'(wlog_addr[(base + 1) % 64]), 128'(25'h1FF_FFF0));
        chk("R6 addr wraps to 0", 128'(wlog_addr[(base + 2) % 64]), 128'(0));
        chk("R6 data 2", wlog_data[(base + 2) % 64], sp_pat(10'h12));
        rd_reg(2'd1, v); chk("R6 main reg linear", 128'(v), 128'(32'h0200_0010));
    endtask

    task automatic t_vu();
        int base = wlog_n;
        int vb = vu_cycles;
        wr_reg(2'd1, 32'h10FF_FFF0);
        wr_reg(2'd3, 32'h0000_0200);
        wr_reg(2'd2, 32'd3);
        wr_reg(2'd0, 32'h3);
        wait_done("R7 done timing", 3);
        chk("R7 below window from main", spad_mem[10'h20], mm_pat(25'h0FF_FFF0));
        chk("R7 window offset 0", spad_mem[10'h21], vu_pat(12'h000));
        chk("R7 window offset 16", spad_mem[10'h22], vu_pat(12'h010));
        vb = vu_cycles;
        wr_reg(2'd1, 32'h1100_0000);
        wr_reg(2'd3, 32'h0000_0000);
        wr_reg(2'd2, 32'd1);
        wr_reg(2'd0, 32'h1);
        wait_done("R7 out-dir timing", 1);
        chk("R7 out-dir goes to main", 128'(wlog_addr[base % 64]), 128'(25'h100_0000));
        chk("R7 out-dir data", wlog_data[base % 64], sp_pat(10'h0));
        chk("R7 out-dir no vector access", 128'(vu_cycles - vb), 128'(0));
    endtask

    task automatic t_zero();
        int eb = en_cycles;
        wr_reg(2'd2, 32'd0);
        wr_reg(2'd0, 32'h3);
        wait_done("R9 zero count done next cycle", 1);
        chk("R9 no port access", 128'(en_cycles - eb), 128'(0));
    endtask

    task automatic t_stall();
        logic [31:0] v;
        wr_reg(2'd1, 32'h0000_0300);
        wr_reg(2'd3, 32'h0000_0800);
        wr_reg(2'd2, 32'd2);
        mm_ready = 1'b0;
        wr_reg(2'd0, 32'h3);
        repeat (3) @(negedge clk);
        rd_reg(2'd2, v); chk("R10 count holds", 128'(v), 128'(2));
        rd_reg(2'd3, v); chk("R10 spad holds", 128'(v), 128'(32'h800));
        chk("R10 no done", 128'(done), 128'(0));
        wr_reg(2'd2, 32'd9);
        wr_reg(2'd3, 32'h0000_0000);
        wr_reg(2'd0, 32'h0);
        rd_reg(2'd2, v); chk("R11 count write ignored", 128'(v), 128'(2));
        rd_reg(2'd3, v); chk("R11 spad write ignored", 128'(v), 128'(32'h800));
        rd_reg(2'd0, v); chk("R11 ctrl write ignored", 128'(v), 128'(3));
        mm_ready = 1'b1;
        wait_done("R10 resume timing", 2);
        chk("R10 data after stall", spad_mem[10'h80], mm_pat(25'h300));
        chk("R10 data after stall+1", spad_mem[10'h81], mm_pat(25'h310));
        rd_reg(2'd1, v); chk("R11 main addr end", 128'(v), 128'(32'h320));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_to_spad();
        t_wrap();
        t_modulo();
        t_vu();
        t_zero();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule